// File: doc/BRIEF.md
# Oscillator Stabilization and Clock-Switch Controller

This block holds the main-clock control of a small microcontroller. Out of reset the CPU and peripherals run from the internal high-speed oscillator. Software does three things over an 8-bit register bus: it enables the external oscillator, picks a stabilization wait, and then asks for the CPU clock to move to the external source. A counter clocked by the oscillator itself measures how long the oscillator has been running. Software sees that elapsed time as a thermometer-coded status byte whose steps are unevenly spaced powers of two.

The switch request is held back in hardware until the selected step has been reached. Software may therefore set the request early and does not have to poll. Stopping the oscillator clears the count and the status, and at once puts the CPU back on the internal oscillator. The analog oscillator is outside the block: `osc_run` tells it to run, and its output returns on `osc_clk`, which is quiet while stopped. The clock multiplexer is replaced by the `cpu_clk_ext` select output.

The parameter `TICK_SHIFT` (default 0) divides every threshold by 2^TICK_SHIFT so that short runs are possible. A threshold written 2^e below means 2^(e-TICK_SHIFT) oscillator cycles.

Top module: `oscstab_clkswitch`

## Requirements
- R1: After reset the register reads are: address 0 (mode) 0x00, address 1 (wait select) 0x07, address 2 (run control) 0x80, address 3 (clock control) 0x00, address 4 (status) 0x00. `cpu_clk_ext` and `osc_run` are 0.
- R2: Writing 0 to bit 7 of address 2 while mode bit 6 is 1 raises `osc_run` and restarts the count from zero, so status reads 0x00 right after the write and then rises.
- R3: Status (address 4) is thermometer coded from bit 7 down. Bits 7,6,5,4,3,2,1,0 set after 2^8, 2^9, 2^10, 2^11, 2^13, 2^15, 2^17 and 2^18 oscillator cycles.
- R4: Wait select code c (address 1, bits 2:0) waits for status bit 7-c: 000=2^8, 001=2^9, 010=2^10, 011=2^11, 100=2^13, 101=2^15, 110=2^17, 111=2^18. Code 010 switches with status 0xE0.
- R5: If request bit 4 of address 3 is set before the wait has elapsed, read-only bit 5 of address 3 and `cpu_clk_ext` stay 0. Both become 1 once the selected status bit is set, with no further write.
- R6: The count saturates at 2^18. Status stays 0xFF while the oscillator keeps running.
- R7: Writing 1 to bit 7 of address 2 clears status to 0x00 and returns `cpu_clk_ext` and bit 5 of address 3 to 0 within two bus cycles.
- R8: While mode bit 6 is 0 the counter is held cleared and `osc_run` is 0. Status stays 0x00 and a switch request is not granted.
- R9: Mode register fields are: bit 7 drives `osc_ext_input` (0 means resonator), bit 6 enables the oscillator, bit 0 drives `osc_hi_gain` (gain for above 10 MHz). Its other bits read 0.
- R10: Clearing request bit 4 returns `cpu_clk_ext` to 0 without disturbing the count. Setting it again while the wait is met switches back within three bus cycles.
- R11: Writes to address 4 and to bit 5 of address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_clk | input | 1 | External oscillator output, gated while stopped |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on address) |
| osc_run | output | 1 | Enable to the analog oscillator |
| osc_ext_input | output | 1 | 1 selects an external clock input instead of a resonator |
| osc_hi_gain | output | 1 | High-frequency gain mode |
| cpu_clk_ext | output | 1 | 1 when the CPU clock is taken from the external oscillator |

## Verification
The hardest case is a switch request that is already pending when the chosen stabilization step arrives. The grant must appear neither early nor late, even though the request and the count live in unrelated clock domains.

The stimulus walks a table of all eight wait codes. For each code it sets the request before releasing the stop bit. It then polls status and clock control on alternate bus cycles and counts the oscillator edges in the bench, which bounds the grant from below by the threshold and from above by a small margin. Saturation is reached by running the longest wait and leaving the oscillator on for more than its period again.

// File: rtl/oscstab_clkswitch.sv
module oscstab_clkswitch #(
  parameter int TICK_SHIFT = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_clk,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       osc_run,
  output logic       osc_ext_input,
  output logic       osc_hi_gain,
  output logic       cpu_clk_ext
);

  localparam int TOP_EXP = 18 - TICK_SHIFT;
  localparam int CNT_W   = TOP_EXP + 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(1) << TOP_EXP;

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_WAIT = 3'd1;
  localparam logic [2:0] A_RUN  = 3'd2;
  localparam logic [2:0] A_CLK  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;

  function automatic int step_exp(input int idx);
    int e;
    case (idx)
      7:       e = 8;
      6:       e = 9;
      5:       e = 10;
      4:       e = 11;
      3:       e = 13;
      2:       e = 15;
      1:       e = 17;
      default: e = 18;
    endcase
    return e - TICK_SHIFT;
  endfunction

  // bus-domain registers
  logic       mode_ext, mode_en, mode_gain;
  logic [2:0] wait_sel;
  logic       main_stop;
  logic       clk_req;
  logic       clk_ext;
  logic [7:0] st_s1, st_s2;

  logic hold;
  logic ready;

  assign hold          = main_stop | ~mode_en;
  assign osc_run       = ~hold;
  assign osc_ext_input = mode_ext;
  assign osc_hi_gain   = mode_gain;
  assign cpu_clk_ext   = clk_ext;
  assign ready         = st_s2[3'd7 - wait_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_ext  <= 1'b0;
      mode_en   <= 1'b0;
      mode_gain <= 1'b0;
      wait_sel  <= 3'b111;
      main_stop <= 1'b1;
      clk_req   <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MODE: begin
          mode_ext  <= bus_wdata[7];
          mode_en   <= bus_wdata[6];
          mode_gain <= bus_wdata[0];
        end
        A_WAIT:  wait_sel  <= bus_wdata[2:0];
        A_RUN:   main_stop <= bus_wdata[7];
        A_CLK:   clk_req   <= bus_wdata[4];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        clk_ext <= 1'b0;
    else if (hold)     clk_ext <= 1'b0;
    else if (!clk_req) clk_ext <= 1'b0;
    else if (ready)    clk_ext <= 1'b1;
  end

  // oscillator domain: reset asserts at once, releases after two oscillator edges
  logic             osc_arst_n;
  logic [1:0]       rst_pipe;
  logic             osc_live;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       therm_d, therm;

  assign osc_arst_n = rst_n & ~hold;
  assign osc_live   = rst_pipe[1];

  always_ff @(posedge osc_clk or negedge osc_arst_n) begin
    if (!osc_arst_n) rst_pipe <= 2'b00;
    else             rst_pipe <= {rst_pipe[0], 1'b1};
  end

  always_ff @(posedge osc_clk or negedge osc_live) begin
    if (!osc_live)            cnt <= '0;
    else if (cnt != CNT_TOP)  cnt <= cnt + 1'b1;
  end

  for (genvar i = 0; i < 8; i++) begin : g_step
    localparam logic [CNT_W-1:0] THR = CNT_W'(1) << step_exp(i);
    assign therm_d[i] = (cnt >= THR);
  end

  always_ff @(posedge osc_clk or negedge osc_live) begin
    if (!osc_live) therm <= 8'h00;
    else           therm <= therm_d;
  end

  // status into bus domain, one bit moves at a time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_s1 <= 8'h00;
      st_s2 <= 8'h00;
    end else if (hold) begin
      st_s1 <= 8'h00;
      st_s2 <= 8'h00;
    end else begin
      st_s1 <= therm;
      st_s2 <= st_s1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = {mode_ext, mode_en, 5'b0, mode_gain};
      A_WAIT:  bus_rdata = {5'b0, wait_sel};
      A_RUN:   bus_rdata = {main_stop, 7'b0};
      A_CLK:   bus_rdata = {2'b0, clk_ext, clk_req, 4'b0};
      A_STAT:  bus_rdata = st_s2;
      default: bus_rdata = 8'h00;
    endcase
  end

  assert_switch_after_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_ext) |-> $past(ready));

  assert_stop_forces_internal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!clk_ext && st_s2 == 8'h00));

  assert_thermo_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (((~st_s2) & ((~st_s2) + 8'd1)) == 8'h00));

  assert_status_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && $past(!hold)) |-> ((st_s2 & $past(st_s2)) == $past(st_s2)));

  assert_request_needed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_req |=> !clk_ext);

  assert_count_saturates_R6: assert property (@(posedge osc_clk) disable iff (!osc_live)
    (cnt == CNT_TOP) |=> (cnt == CNT_TOP && therm == 8'hFF));

endmodule

// File: tb/oscstab_clkswitch_tb.sv
module oscstab_clkswitch_tb;
  localparam int SHIFT = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_clk = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       osc_run, osc_ext_input, osc_hi_gain, cpu_clk_ext;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int osc_edges = 0;

  oscstab_clkswitch #(.TICK_SHIFT(SHIFT)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .osc_run(osc_run), .osc_ext_input(osc_ext_input),
    .osc_hi_gain(osc_hi_gain), .cpu_clk_ext(cpu_clk_ext)
  );

  always #10 clk = ~clk;

  always begin
    #5;
    if (osc_run || osc_clk) osc_clk = ~osc_clk;
  end

  always @(posedge osc_clk) osc_edges++;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // per wait code: expected status at grant and threshold exponent
  localparam logic [7:0] EXP_ST [8] = '{8'h80, 8'hC0, 8'hE0, 8'hF0, 8'hF8, 8'hFC, 8'hFE, 8'hFF};
  localparam int         EXP_E  [8] = '{8, 9, 10, 11, 13, 15, 17, 18};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [7:0] rd, st, sc;
  int base, thr, el;

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    bus_read(3'd0, rd); chk("R1 mode", rd, 8'h00);
    bus_read(3'd1, rd); chk("R1 wait", rd, 8'h07);
    bus_read(3'd2, rd); chk("R1 run", rd, 8'h80);
    bus_read(3'd3, rd); chk("R1 clk", rd, 8'h00);
    bus_read(3'd4, rd); chk("R1 status", rd, 8'h00);
    chk("R1 outputs", {6'b0, osc_run, cpu_clk_ext}, 8'h00);

    // R9 mode fields
    bus_write(3'd0, 8'hFF);
    bus_read(3'd0, rd); chk("R9 mode read", rd, 8'hC1);
    chk("R9 pins", {5'b0, osc_ext_input, osc_hi_gain, osc_run}, 8'h06);
    bus_write(3'd0, 8'h40);
    bus_read(3'd0, rd); chk("R9 mode rewrite", rd, 8'h40);
    chk("R9 pins off", {6'b0, osc_ext_input, osc_hi_gain}, 8'h00);

    // R8 oscillator disabled holds counter clear
    bus_write(3'd0, 8'h00);
    bus_write(3'd1, 8'h00);
    bus_write(3'd3, 8'h10);
    bus_write(3'd2, 8'h00);
    idle(400);
    chk("R8 osc_run", {7'b0, osc_run}, 8'h00);
    bus_read(3'd4, rd); chk("R8 status held", rd, 8'h00);
    bus_read(3'd3, rd); chk("R8 no grant", rd, 8'h10);
    bus_write(3'd3, 8'h00);
    bus_write(3'd2, 8'h80);
    bus_write(3'd0, 8'h40);

    // R4/R5 walk every wait code with an early request
    for (int c = 0; c < 8; c++) begin
      thr = 1 << (EXP_E[c] - SHIFT);
      bus_write(3'd1, 8'(c));
      bus_write(3'd3, 8'h10);
      base = osc_edges;
      bus_write(3'd2, 8'h00);
      bus_read(3'd3, rd); chk($sformatf("R5 early hold code %0d", c), rd, 8'h10);
      st = 8'h00;
      sc = 8'h00;
      for (int k = 0; k < 6000; k++) begin
        bus_read(3'd4, st);
        bus_read(3'd3, sc);
        if (sc[5]) break;
        if (st[7-c] && k > 8) break;
      end
      el = osc_edges - base;
      chk($sformatf("R5 grant code %0d", c), sc, 8'h30);
      chk($sformatf("R4 status at grant code %0d", c), st & EXP_ST[c], EXP_ST[c]);
      chk($sformatf("R4 not early code %0d", c), {7'b0, (el >= thr)}, 8'h01);
      chk($sformatf("R4 not late code %0d", c), {7'b0, (el <= thr + 64)}, 8'h01);
      chk($sformatf("R5 pin code %0d", c), {7'b0, cpu_clk_ext}, 8'h01);
      bus_write(3'd2, 8'h80);
      idle(1);
      bus_read(3'd4, rd); chk($sformatf("R7 status cleared code %0d", c), rd, 8'h00);
      bus_read(3'd3, rd); chk($sformatf("R7 back internal code %0d", c), rd, 8'h10);
      chk($sformatf("R7 pin code %0d", c), {7'b0, cpu_clk_ext}, 8'h00);
      bus_write(3'd3, 8'h00);
    end

    // R2 restart from zero, R10 release and re-grant, R11 read-only writes
    bus_write(3'd1, 8'h00);
    bus_write(3'd3, 8'h10);
    bus_write(3'd2, 8'h00);
    chk("R2 osc_run", {7'b0, osc_run}, 8'h01);
    bus_read(3'd4, rd); chk("R2 restart at zero", rd, 8'h00);
    idle(100);
    bus_read(3'd4, rd); chk("R2 counting", rd & 8'h80, 8'h80);
    bus_read(3'd3, rd); chk("R10 granted", rd, 8'h30);
    bus_write(3'd3, 8'h00);
    idle(1);
    bus_read(3'd3, rd); chk("R10 released", rd, 8'h00);
    chk("R10 pin", {7'b0, cpu_clk_ext}, 8'h00);
    bus_read(3'd4, rd); chk("R10 count kept", rd & 8'h80, 8'h80);
    bus_write(3'd4, 8'h00);
    bus_read(3'd4, rd); chk("R11 status write ignored", rd & 8'h80, 8'h80);
    bus_write(3'd3, 8'h20);
    bus_read(3'd3, rd); chk("R11 bit5 read-only", rd, 8'h00);
    bus_write(3'd3, 8'h10);
    idle(1);
    bus_read(3'd3, rd); chk("R10 re-grant", rd, 8'h30);
    bus_write(3'd2, 8'h80);

    // R6 saturation with the longest wait
    bus_write(3'd1, 8'h07);
    bus_write(3'd2, 8'h00);
    rd = 8'h00;
    for (int k = 0; k < 5000; k++) begin
      bus_read(3'd4, rd);
      if (rd == 8'hFF) break;
    end
    chk("R3 full thermometer", rd, 8'hFF);
    idle(3000);
    bus_read(3'd4, rd); chk("R6 saturated", rd, 8'hFF);
    bus_read(3'd3, rd); chk("R6 granted at longest", rd, 8'h30);
    bus_write(3'd2, 8'h80);
    idle(1);
    bus_read(3'd4, rd); chk("R7 clear after saturation", rd, 8'h00);
    chk("R7 pin after saturation", {6'b0, osc_run, cpu_clk_ext}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule